// File: doc/BRIEF.md
# Fractional Divide-Ratio Modulator

This block supplies the modulus for a fractional-N feedback divider. Each time the divider finishes a count, it raises an update strobe. The block then returns the next integer divide value. Over time the average of these values equals an integer setting plus a fractional setting. The fractional setting always carries a built-in half-LSB bias. The dither comes from a cascade of three first-order accumulators, each with its own error feedback. This pushes the quantisation noise of the ratio toward high offset frequencies.

When low noise matters more than fine frequency resolution, an integer-only mode bypasses the modulator. The modulus then stays fixed at the integer setting. A synchronous clear puts the modulator back to a known starting point. The counter that divides the clock, the oscillator and the phase detector are outside this block.

Top module: `frac_ratio_mod`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and modulus_o is 0.
- R2: valid_o is 1 in the cycle after a clock edge at which upd_i is 1 and clr_i is 0; otherwise valid_o is 0.
- R3: At an edge where upd_i is 0, the modulator state does not change and modulus_o holds its value.
- R4: At an update with int_only_i high, modulus_o becomes int_part_i and all modulator state is cleared.
- R5: At an update with int_only_i low, the modulator input is the (FRAC_W+1)-bit word x = {frac_part_i, 1}. Stage 1 adds x to its accumulator (modulo 2^(FRAC_W+1)). Stage k adds the updated accumulator of stage k-1. Each stage raises a carry c1, c2 or c3 on wrap. The offset is y = c1 + c2 - c2' + c3 - 2*c3' + c3'', where ' and '' are the carries of the previous update and of the update before it. modulus_o becomes int_part_i + y, in two's complement with INT_W+2 bits.
- R6: The offset modulus_o - int_part_i of a fractional update lies in -3..+4.
- R7: Over 2^(FRAC_W+1) consecutive updates after a clear, with constant settings, the sum of modulus_o is within 1 of 2^(FRAC_W+1)*int_part_i + 2*frac_part_i + 1.
- R8: At an edge where clr_i is 1, all accumulators and carry history are cleared, and valid_o is 0 in the next cycle.
- R9: New int_part_i or frac_part_i values are used by the update at which they are present, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of modulator state |
| upd_i | input | 1 | Update strobe, one per feedback count |
| int_only_i | input | 1 | Integer-only mode, bypasses the modulator |
| int_part_i | input | INT_W | Integer part of the ratio |
| frac_part_i | input | FRAC_W | Fractional part of the ratio |
| modulus_o | output | INT_W+2 | Signed modulus for the next count |
| valid_o | output | 1 | modulus_o was updated on the last edge |

## Verification
The hardest property to show is R7. It only appears once the accumulators have gone through a complete fractional period. The state that the third stage reaches at that point can only be seen through long runs of updates. The bench therefore builds the block with a narrow fractional word, so a full period takes two thousand updates. It runs several complete periods from a clear, with random and extreme settings. In every cycle it compares the output against a reference recurrence. It also sums each window against the bound.

// File: rtl/frac_ratio_pkg.sv
package frac_ratio_pkg;
  // offset range -3..+4 fits a 4-bit signed value
  localparam int unsigned NOISE_W = 4;
  typedef logic signed [NOISE_W-1:0] noise_t;
endpackage

// File: rtl/frac_acc_stage.sv
module frac_acc_stage #(
  parameter int unsigned ACC_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [ACC_W-1:0] add_i,
  output logic [ACC_W-1:0] acc_nxt_o,
  output logic             carry_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum       = {1'b0, acc_q} + {1'b0, add_i};
  assign acc_nxt_o = sum[ACC_W-1:0];
  assign carry_o   = sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (step_i)  acc_q <= acc_nxt_o;
  end
endmodule

// File: rtl/frac_noise_comb.sv
module frac_noise_comb
  import frac_ratio_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   step_i,
  input  logic   c1_i,
  input  logic   c2_i,
  input  logic   c3_i,
  output noise_t y_o
);
  logic c2_d, c3_d, c3_dd;

  // differentiate stage 2 once and stage 3 twice
  assign y_o = noise_t'({3'b0, c1_i}) + noise_t'({3'b0, c2_i}) - noise_t'({3'b0, c2_d})
             + noise_t'({3'b0, c3_i}) - noise_t'({2'b0, c3_d, 1'b0}) + noise_t'({3'b0, c3_dd});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2_d <= 1'b0; c3_d <= 1'b0; c3_dd <= 1'b0;
    end else if (clr_i) begin
      c2_d <= 1'b0; c3_d <= 1'b0; c3_dd <= 1'b0;
    end else if (step_i) begin
      c2_d <= c2_i; c3_d <= c3_i; c3_dd <= c3_d;
    end
  end
endmodule

// File: rtl/frac_ratio_mod.sv
module frac_ratio_mod
  import frac_ratio_pkg::*;
#(
  parameter int unsigned INT_W  = 7,
  parameter int unsigned FRAC_W = 18,
  parameter int unsigned STAGES = 3,
  localparam int unsigned ACC_W = FRAC_W + 1,
  localparam int unsigned MOD_W = INT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic              int_only_i,
  input  logic [INT_W-1:0]  int_part_i,
  input  logic [FRAC_W-1:0] frac_part_i,
  output logic [MOD_W-1:0]  modulus_o,
  output logic              valid_o
);
  logic             stage_clr;
  logic             step;
  logic [ACC_W-1:0] stage_in  [STAGES];
  logic [ACC_W-1:0] stage_nxt [STAGES];
  logic [STAGES-1:0] carry;
  noise_t           y;
  logic [MOD_W-1:0] mod_nxt;

  assign stage_clr = clr_i | (upd_i & int_only_i);
  assign step      = upd_i & ~int_only_i;

  // half-LSB bias as a fixed low bit
  assign stage_in[0] = {frac_part_i, 1'b1};

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k > 0) begin : g_chain
      assign stage_in[k] = stage_nxt[k-1];
    end
    frac_acc_stage #(.ACC_W(ACC_W)) u_acc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (stage_clr),
      .step_i    (step),
      .add_i     (stage_in[k]),
      .acc_nxt_o (stage_nxt[k]),
      .carry_o   (carry[k])
    );
  end

  frac_noise_comb u_comb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (stage_clr),
    .step_i (step),
    .c1_i   (carry[0]),
    .c2_i   (carry[1]),
    .c3_i   (carry[2]),
    .y_o    (y)
  );

  always_comb begin
    if (int_only_i) mod_nxt = {2'b00, int_part_i};
    else            mod_nxt = {2'b00, int_part_i} + {{(MOD_W-NOISE_W){y[NOISE_W-1]}}, y};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      modulus_o <= '0;
      valid_o   <= 1'b0;
    end else if (clr_i) begin
      valid_o   <= 1'b0;
    end else begin
      valid_o <= upd_i;
      if (upd_i) modulus_o <= mod_nxt;
    end
  end
endmodule

// File: rtl/frac_ratio_mod_chk.sv
module frac_ratio_mod_chk #(
  parameter int unsigned INT_W = 7,
  parameter int unsigned MOD_W = INT_W + 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             upd_i,
  input logic             int_only_i,
  input logic [INT_W-1:0] int_part_i,
  input logic [MOD_W-1:0] modulus_o,
  input logic             valid_o
);
  logic [INT_W-1:0] int_q;
  logic             frac_upd_q;
  logic signed [MOD_W-1:0] off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= '0; frac_upd_q <= 1'b0;
    end else begin
      int_q      <= int_part_i;
      frac_upd_q <= upd_i & ~clr_i & ~int_only_i;
    end
  end
  assign off = $signed(modulus_o) - $signed({2'b00, int_q});

  p_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clr_i) |=> valid_o);
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i || clr_i) |=> !valid_o);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(modulus_o));
  p_int_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clr_i && int_only_i) |=> (modulus_o == {2'b00, $past(int_part_i)}));
  p_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frac_upd_q |-> (off >= -3 && off <= 4));
  p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_o);
endmodule

bind frac_ratio_mod frac_ratio_mod_chk #(.INT_W(INT_W), .MOD_W(MOD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .upd_i      (upd_i),
  .int_only_i (int_only_i),
  .int_part_i (int_part_i),
  .modulus_o  (modulus_o),
  .valid_o    (valid_o)
);

// File: tb/tb_frac_ratio_mod.sv
module tb_frac_ratio_mod;
  localparam int CLK_PERIOD = 10;
  localparam int INT_W  = 7;
  localparam int FRAC_W = 10;
  localparam int ACC_W  = FRAC_W + 1;
  localparam int MOD_W  = INT_W + 2;
  localparam int NPER   = 1 << ACC_W;

  logic clk_i = 1'b0, rst_ni = 1'b0, clr_i = 1'b0, upd_i = 1'b0, int_only_i = 1'b0;
  logic [INT_W-1:0]  int_part_i = '0;
  logic [FRAC_W-1:0] frac_part_i = '0;
  logic [MOD_W-1:0]  modulus_o;
  logic              valid_o;

  int checks = 0, errors = 0;
  int a1, a2, a3, h2, h3, h33, exp_mod;
  longint wsum;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  frac_ratio_mod #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut (
    .clk_i, .rst_ni, .clr_i, .upd_i, .int_only_i, .int_part_i, .frac_part_i,
    .modulus_o, .valid_o);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int signed_mod(input logic [MOD_W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic model_clear();
    a1 = 0; a2 = 0; a3 = 0; h2 = 0; h3 = 0; h33 = 0;
  endtask

  // reference recurrence from R5
  function automatic int model_step(input int ip, input int fp);
    int x, c1, c2, c3, y;
    x  = fp * 2 + 1;
    a1 = a1 + x;  c1 = (a1 >= NPER); a1 = a1 % NPER;
    a2 = a2 + a1; c2 = (a2 >= NPER); a2 = a2 % NPER;
    a3 = a3 + a2; c3 = (a3 >= NPER); a3 = a3 % NPER;
    y  = c1 + c2 - h2 + c3 - 2*h3 + h33;
    h33 = h3; h3 = c3; h2 = c2;
    return ip + y;
  endfunction

  task automatic cyc(input bit u, input bit c, input bit io);
    @(negedge clk_i);
    upd_i = u; clr_i = c; int_only_i = io;
    @(posedge clk_i); #1;
  endtask

  task automatic do_clear();
    cyc(0, 1, 0);
    model_clear();
    chk("R8 valid after clear", valid_o, 0);
  endtask

  task automatic frac_upd(input string req);
    cyc(1, 0, 0);
    exp_mod = model_step(int'(int_part_i), int'(frac_part_i));
    chk(req, signed_mod(modulus_o), exp_mod);
    if (signed_mod(modulus_o) - int'(int_part_i) < -3 || signed_mod(modulus_o) - int'(int_part_i) > 4)
      chk("R6 offset range", signed_mod(modulus_o) - int'(int_part_i), 0);
    wsum += signed_mod(modulus_o);
  endtask

  task automatic window(input int ip, input int fp);
    longint target;
    @(negedge clk_i);
    int_part_i = INT_W'(ip); frac_part_i = FRAC_W'(fp);
    do_clear();
    wsum = 0;
    for (int i = 0; i < NPER; i++) frac_upd("R5 modulus sequence");
    target = longint'(NPER) * ip + 2 * fp + 1;
    checks++;
    if (wsum < target - 1 || wsum > target + 1) begin
      errors++;
      $display("FAIL R7 window sum actual=%0d expected=%0d", wsum, target);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    #(CLK_PERIOD*2 + 3);
    chk("R1 reset valid", valid_o, 0);
    chk("R1 reset modulus", modulus_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    model_clear();

    // R2 idle gives no strobe
    cyc(0, 0, 0);
    chk("R2 no strobe without update", valid_o, 0);

    // R4 integer mode
    int_part_i = 7'd45; frac_part_i = 10'd333;
    cyc(1, 0, 1);
    chk("R4 integer modulus", modulus_o, 45);
    chk("R2 strobe after update", valid_o, 1);
    cyc(1, 0, 1);
    chk("R4 integer modulus held", modulus_o, 45);

    // R5 and R9 with a change mid run
    model_clear();
    for (int i = 0; i < 20; i++) frac_upd("R5 after integer mode");
    int_part_i = 7'd90; frac_part_i = 10'd1000;
    frac_upd("R9 new setting used at once");

    // R3 hold: idle cycles then continue sequence
    cyc(0, 0, 0);
    chk("R3 modulus held", signed_mod(modulus_o), exp_mod);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0);
    for (int i = 0; i < 10; i++) frac_upd("R3 state kept over idle");

    // R2 clear has priority over update
    cyc(1, 1, 0);
    model_clear();
    chk("R8 clear beats update", valid_o, 0);
    for (int i = 0; i < 10; i++) frac_upd("R8 sequence restarts");

    // R4 clears modulator state
    cyc(1, 0, 1);
    model_clear();
    for (int i = 0; i < 10; i++) frac_upd("R4 state cleared by integer update");

    // R7 windows: corners and random
    window(0, 0);
    window(127, (1 << FRAC_W) - 1);
    window(3, 1);
    for (int k = 0; k < 6; k++) window($urandom_range(0, 127), $urandom_range(0, (1 << FRAC_W) - 1));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule